// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block answers a processor's move-to and move-from special-register instructions. A 16-bit register number is formed from a 5-bit group in the upper bits and an 11-bit index in the lower bits, so the full number is group·2048 + index. The unit decodes that number and holds the registers behind it: the exception vector base, the exception PC, the effective address of the fault, the exception status word and a general status word. It also holds a 64-bit multiply-accumulate value seen as two 32-bit halves, an interrupt mask and an interrupt status word, and a power-management word that can ask the core to halt. Two read-only identity words, core number and core count, come from parameters.

Reads are combinational. Whatever number is on `addr_i`, `rdata_o` shows the selected register in the same cycle. If the number is not mapped, `rdata_o` shows the caller's default value `rd_dflt_i`, which is normally the old contents of the destination register. A write strobe commits `wdata_i` on the next rising clock edge. Interrupt events come in on `irq_set_i` and set the matching status bits. Software clears status bits by writing ones.

Top module: `spr_access_unit`

## Requirements
- R1: A register responds only at its full number group·2048+index: group 0 idx 11 vector base, 17 status, 32 exception PC, 48 effective address, 64 exception status; group 5 idx 1/2 accumulator low/high; group 8 idx 0 power; group 9 idx 0 mask, idx 2 interrupt status; group 0 idx 128/129 core number/count. The same index in a different group is unmapped.
- R2: The five group-0 exception and status registers read back the last value written to them.
- R3: A write to one accumulator half changes those 32 bits and leaves the other half unchanged.
- R4: The interrupt mask is an ordinary read/write register.
- R5: A write to the interrupt status register clears each bit that is 1 in the write data and keeps each bit written 0. Every cycle, bits set on `irq_set_i` are set, and in the same cycle a set takes priority over a clear.
- R6: Writing the power register stores the data. If bit 4 (doze) or bit 5 (sleep) is 1, `halt_o` is high for exactly the following cycle, and `resume_pc_o` then holds `pc_i`+4, where `pc_i` is the value at the time of the write.
- R7: A power register write with bits 4 and 5 both 0 does not raise `halt_o`, and `resume_pc_o` keeps its value.
- R8: Core number reads parameter CORE_ID and core count reads NUM_CORES. Writes to them have no effect.
- R9: A read of an unmapped number returns `rd_dflt_i` unchanged.
- R10: A write to an unmapped number changes no register.
- R11: While `rst_ni` is low and after it is released, every writable register reads 0, `halt_o` is 0 and `resume_pc_o` is 0.
- R12: Read data is combinational from `addr_i`. A write is visible on a read from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| addr_i | input | 16 | register number, group in [15:11], index in [10:0] |
| wr_en_i | input | 1 | write strobe |
| wdata_i | input | 32 | write data |
| rd_dflt_i | input | 32 | value returned for unmapped reads |
| irq_set_i | input | 32 | interrupt events that set status bits |
| pc_i | input | 32 | PC of the instruction being executed |
| rdata_o | output | 32 | read data |
| halt_o | output | 1 | one-cycle halt request |
| resume_pc_o | output | 32 | PC at which to resume after a halt |

## Verification
The bench builds the unit with CORE_ID=3 and NUM_CORES=4. With these values the identity reads differ from the zero that the writable registers take at reset, and from a default value that was passed through by mistake. Random traffic is spread over every mapped number, over the same indices in the wrong groups and over arbitrary numbers. This covers aliasing across groups, writes to unmapped numbers and the read-only words. Sparse interrupt events land in the same cycles as clearing writes, which exercises the set-over-clear priority. Power writes with random data cover both bits, either bit alone and neither bit, including back-to-back halts.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int GRP_W  = 5;
  localparam int IDX_W  = 11;
  localparam int ADDR_W = GRP_W + IDX_W;
  localparam int DW     = 32;
  localparam int MAC_W  = 2 * DW;
  localparam int DOZE_BIT  = 4;
  localparam int SLEEP_BIT = 5;

  function automatic logic [ADDR_W-1:0] spr_num(int grp, int idx);
    return ADDR_W'((grp << IDX_W) + idx);
  endfunction

  localparam logic [ADDR_W-1:0] A_VBASE  = spr_num(0, 11);
  localparam logic [ADDR_W-1:0] A_STAT   = spr_num(0, 17);
  localparam logic [ADDR_W-1:0] A_EPC    = spr_num(0, 32);
  localparam logic [ADDR_W-1:0] A_EEA    = spr_num(0, 48);
  localparam logic [ADDR_W-1:0] A_ESTAT  = spr_num(0, 64);
  localparam logic [ADDR_W-1:0] A_COREID = spr_num(0, 128);
  localparam logic [ADDR_W-1:0] A_NCORES = spr_num(0, 129);
  localparam logic [ADDR_W-1:0] A_MACLO  = spr_num(5, 1);
  localparam logic [ADDR_W-1:0] A_MACHI  = spr_num(5, 2);
  localparam logic [ADDR_W-1:0] A_PWR    = spr_num(8, 0);
  localparam logic [ADDR_W-1:0] A_IMASK  = spr_num(9, 0);
  localparam logic [ADDR_W-1:0] A_ISTAT  = spr_num(9, 2);

  typedef enum logic [3:0] {
    SEL_NONE, SEL_VBASE, SEL_STAT, SEL_EPC, SEL_EEA, SEL_ESTAT,
    SEL_PWR, SEL_IMASK, SEL_MACLO, SEL_MACHI, SEL_ISTAT,
    SEL_COREID, SEL_NCORES
  } spr_sel_e;

  // plain read/write words, stored in a generated bank
  localparam int NPLAIN = 7;

  function automatic spr_sel_e plain_sel(int k);
    case (k)
      0:       return SEL_VBASE;
      1:       return SEL_STAT;
      2:       return SEL_EPC;
      3:       return SEL_EEA;
      4:       return SEL_ESTAT;
      5:       return SEL_PWR;
      default: return SEL_IMASK;
    endcase
  endfunction

  typedef struct packed {
    logic [DW-1:0]    vbase;
    logic [DW-1:0]    stat;
    logic [DW-1:0]    epc;
    logic [DW-1:0]    eea;
    logic [DW-1:0]    estat;
    logic [DW-1:0]    pwr;
    logic [DW-1:0]    imask;
    logic [MAC_W-1:0] mac;
    logic [DW-1:0]    istat;
  } spr_state_t;
endpackage

// File: rtl/spr_addr_decode.sv
module spr_addr_decode
  import spr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output spr_sel_e          sel_o
);
  always_comb begin
    unique case (addr_i)
      A_VBASE:  sel_o = SEL_VBASE;
      A_STAT:   sel_o = SEL_STAT;
      A_EPC:    sel_o = SEL_EPC;
      A_EEA:    sel_o = SEL_EEA;
      A_ESTAT:  sel_o = SEL_ESTAT;
      A_COREID: sel_o = SEL_COREID;
      A_NCORES: sel_o = SEL_NCORES;
      A_MACLO:  sel_o = SEL_MACLO;
      A_MACHI:  sel_o = SEL_MACHI;
      A_PWR:    sel_o = SEL_PWR;
      A_IMASK:  sel_o = SEL_IMASK;
      A_ISTAT:  sel_o = SEL_ISTAT;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/spr_word_reg.sv
module spr_word_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/spr_reg_bank.sv
module spr_reg_bank
  import spr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  spr_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] irq_set_i,
  output spr_state_t    st_o
);
  logic [DW-1:0]    plain_q [NPLAIN];
  logic [MAC_W-1:0] mac_q;
  logic [DW-1:0]    istat_q;

  for (genvar k = 0; k < NPLAIN; k++) begin : g_plain
    spr_word_reg #(.W(DW)) u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (wr_en_i && (sel_i == plain_sel(k))),
      .d_i    (wdata_i),
      .q_o    (plain_q[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mac_q <= '0;
    end else if (wr_en_i) begin
      if (sel_i == SEL_MACLO) mac_q[DW-1:0]     <= wdata_i;
      if (sel_i == SEL_MACHI) mac_q[MAC_W-1:DW] <= wdata_i;
    end
  end

  // write-one-to-clear; new events win over a clear in the same cycle
  logic [DW-1:0] istat_clr;
  assign istat_clr = (wr_en_i && sel_i == SEL_ISTAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) istat_q <= '0;
    else         istat_q <= (istat_q & ~istat_clr) | irq_set_i;
  end

  always_comb begin
    st_o.vbase = plain_q[0];
    st_o.stat  = plain_q[1];
    st_o.epc   = plain_q[2];
    st_o.eea   = plain_q[3];
    st_o.estat = plain_q[4];
    st_o.pwr   = plain_q[5];
    st_o.imask = plain_q[6];
    st_o.mac   = mac_q;
    st_o.istat = istat_q;
  end
endmodule

// File: rtl/spr_halt_ctl.sv
module spr_halt_ctl
  import spr_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            halt_o,
  output logic [PC_W-1:0] resume_pc_o
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic req_halt;
  assign req_halt = pwr_wr_i && (wdata_i[DOZE_BIT] || wdata_i[SLEEP_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o      <= 1'b0;
      resume_pc_o <= '0;
    end else begin
      halt_o <= req_halt;
      if (req_halt) resume_pc_o <= pc_i + INSN_BYTES;
    end
  end
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int CORE_ID   = 0,
  parameter int NUM_CORES = 1,
  parameter int PC_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     rd_dflt_i,
  input  logic [DW-1:0]     irq_set_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [DW-1:0]     rdata_o,
  output logic              halt_o,
  output logic [PC_W-1:0]   resume_pc_o
);
  spr_sel_e   sel;
  spr_state_t st;

  spr_addr_decode u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  spr_reg_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .sel_i     (sel),
    .wdata_i   (wdata_i),
    .irq_set_i (irq_set_i),
    .st_o      (st)
  );

  spr_halt_ctl #(.PC_W(PC_W)) u_halt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_wr_i    (wr_en_i && sel == SEL_PWR),
    .wdata_i     (wdata_i),
    .pc_i        (pc_i),
    .halt_o      (halt_o),
    .resume_pc_o (resume_pc_o)
  );

  always_comb begin
    unique case (sel)
      SEL_VBASE:  rdata_o = st.vbase;
      SEL_STAT:   rdata_o = st.stat;
      SEL_EPC:    rdata_o = st.epc;
      SEL_EEA:    rdata_o = st.eea;
      SEL_ESTAT:  rdata_o = st.estat;
      SEL_PWR:    rdata_o = st.pwr;
      SEL_IMASK:  rdata_o = st.imask;
      SEL_MACLO:  rdata_o = st.mac[DW-1:0];
      SEL_MACHI:  rdata_o = st.mac[MAC_W-1:DW];
      SEL_ISTAT:  rdata_o = st.istat;
      SEL_COREID: rdata_o = DW'(CORE_ID);
      SEL_NCORES: rdata_o = DW'(NUM_CORES);
      default:    rdata_o = rd_dflt_i;
    endcase
  end
endmodule

// File: rtl/spr_access_chk.sv
module spr_access_chk
  import spr_pkg::*;
#(
  parameter int CORE_ID   = 0,
  parameter int NUM_CORES = 1,
  parameter int PC_W      = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     irq_set_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [DW-1:0]     rdata_o,
  input logic              halt_o,
  input logic [PC_W-1:0]   resume_pc_o,
  input spr_state_t        st
);
  // R6
  halt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> $past(wr_en_i && addr_i == A_PWR &&
                     (wdata_i[DOZE_BIT] || wdata_i[SLEEP_BIT])));

  // R6
  resume_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> resume_pc_o == $past(pc_i) + PC_W'(4));

  // R7
  resume_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_o |-> $stable(resume_pc_o));

  // R5
  istat_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_ISTAT) |=>
      st.istat == (($past(st.istat) & ~$past(wdata_i)) | $past(irq_set_i)));

  // R3
  mac_lo_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MACLO) |=> $stable(st.mac[MAC_W-1:DW]));

  // R3
  mac_hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MACHI) |=> $stable(st.mac[DW-1:0]));

  // R4
  imask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_IMASK) |=> $stable(st.imask));

  // R8
  coreid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_COREID) |-> rdata_o == DW'(CORE_ID));
endmodule

bind spr_access_unit spr_access_chk #(
  .CORE_ID(CORE_ID), .NUM_CORES(NUM_CORES), .PC_W(PC_W)
) u_chk (.*);

// File: tb/spr_access_unit_bench.sv
module spr_access_unit_bench;
  localparam int CID = 3;
  localparam int NCR = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0, rd_dflt_i = '0, irq_set_i = '0, pc_i = '0;
  logic [31:0] rdata_o, resume_pc_o;
  logic        halt_o;

  int total = 0, bad = 0;

  always #5ns clk_i = ~clk_i;

  spr_access_unit #(.CORE_ID(CID), .NUM_CORES(NCR)) u_spr_access_unit (.*);

  // reference state
  logic [31:0] m_vb, m_st, m_epc, m_eea, m_es, m_pwr, m_im, m_is, m_rpc;
  logic [63:0] m_mac;
  logic        m_halt;

  function automatic string req_of(logic [15:0] a);
    int g = int'(a >> 11);
    int i = int'(a & 16'h07ff);
    if (g == 0 && (i == 11 || i == 17 || i == 32 || i == 48 || i == 64)) return "R2";
    if (g == 0 && (i == 128 || i == 129)) return "R8";
    if (g == 5 && (i == 1 || i == 2)) return "R3";
    if (g == 8 && i == 0) return "R6";
    if (g == 9 && i == 0) return "R4";
    if (g == 9 && i == 2) return "R5";
    return "R9";
  endfunction

  function automatic logic [31:0] m_read(logic [15:0] a, logic [31:0] d);
    int g = int'(a >> 11);
    int i = int'(a & 16'h07ff);
    if (g == 0) begin
      if (i == 11) return m_vb;
      if (i == 17) return m_st;
      if (i == 32) return m_epc;
      if (i == 48) return m_eea;
      if (i == 64) return m_es;
      if (i == 128) return CID;
      if (i == 129) return NCR;
    end
    if (g == 5 && i == 1) return m_mac[31:0];
    if (g == 5 && i == 2) return m_mac[63:32];
    if (g == 8 && i == 0) return m_pwr;
    if (g == 9 && i == 0) return m_im;
    if (g == 9 && i == 2) return m_is;
    return d;
  endfunction

  task automatic m_reset();
    m_vb = 0; m_st = 0; m_epc = 0; m_eea = 0; m_es = 0; m_pwr = 0;
    m_im = 0; m_is = 0; m_rpc = 0; m_mac = 0; m_halt = 0;
  endtask

  task automatic m_step();
    int g = int'(addr_i >> 11);
    int i = int'(addr_i & 16'h07ff);
    logic h = 1'b0;
    if (wr_en_i) begin
      if (g == 0 && i == 11) m_vb = wdata_i;
      if (g == 0 && i == 17) m_st = wdata_i;
      if (g == 0 && i == 32) m_epc = wdata_i;
      if (g == 0 && i == 48) m_eea = wdata_i;
      if (g == 0 && i == 64) m_es = wdata_i;
      if (g == 5 && i == 1) m_mac[31:0] = wdata_i;
      if (g == 5 && i == 2) m_mac[63:32] = wdata_i;
      if (g == 9 && i == 0) m_im = wdata_i;
      if (g == 9 && i == 2) m_is = m_is & ~wdata_i;
      if (g == 8 && i == 0) begin
        m_pwr = wdata_i;
        if (wdata_i[4] || wdata_i[5]) begin
          h = 1'b1;
          m_rpc = pc_i + 32'd4;
        end
      end
    end
    m_is = m_is | irq_set_i;
    m_halt = h;
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h act=%h exp=%h t=%0t", r, addr_i, act, exp, $time);
    end
  endtask

  // one clock: apply, check outputs, then advance the model at the edge
  task automatic cyc(logic we, logic [15:0] a, logic [31:0] wd,
                     logic [31:0] dflt, logic [31:0] irq, logic [31:0] pc);
    wr_en_i = we; addr_i = a; wdata_i = wd; rd_dflt_i = dflt;
    irq_set_i = irq; pc_i = pc;
    #1;
    chk(req_of(a), rdata_o, m_read(a, dflt));    // R12: same-cycle read
    chk("R6", {31'b0, halt_o}, {31'b0, m_halt});
    chk("R7", resume_pc_o, m_rpc);
    @(posedge clk_i);
    if (rst_ni) m_step();
    @(negedge clk_i);
  endtask

  function automatic logic [15:0] pick_addr(int k);
    case (k % 16)
      0:  return 16'd11;
      1:  return 16'd17;
      2:  return 16'd32;
      3:  return 16'd48;
      4:  return 16'd64;
      5:  return 16'd128;
      6:  return 16'd129;
      7:  return (16'd5 << 11) + 16'd1;
      8:  return (16'd5 << 11) + 16'd2;
      9:  return 16'd8 << 11;
      10: return 16'd9 << 11;
      11: return (16'd9 << 11) + 16'd2;
      12: return (16'(1 + $urandom_range(0, 30)) << 11) + 16'd11; // R1 alias
      13: return (16'd3 << 11) + 16'd2;                            // R1 alias
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #2ms;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reset();
    @(negedge clk_i);
    // R11: reset state, writes during reset have no effect
    cyc(1'b1, 16'd11, 32'hdead_beef, 32'h1, 32'h0, 32'h100);
    chk("R11", rdata_o, 32'h0);
    m_reset();
    rst_ni = 1'b1;
    cyc(1'b0, 16'd11, 0, 32'h5555_0000, 0, 0);
    chk("R11", rdata_o, 32'h0);

    // R2 / R12: write then read back next cycle
    cyc(1'b1, 16'd32, 32'h1234_5678, 0, 0, 0);
    cyc(1'b0, 16'd32, 0, 0, 0, 0);
    chk("R2", rdata_o, 32'h1234_5678);

    // R3: halves independent
    cyc(1'b1, (16'd5 << 11) + 1, 32'haaaa_0001, 0, 0, 0);
    cyc(1'b1, (16'd5 << 11) + 2, 32'hbbbb_0002, 0, 0, 0);
    cyc(1'b1, (16'd5 << 11) + 1, 32'hcccc_0003, 0, 0, 0);
    cyc(1'b0, (16'd5 << 11) + 2, 0, 0, 0, 0);
    chk("R3", rdata_o, 32'hbbbb_0002);

    // R5: W1C with a same-cycle set on a cleared bit
    cyc(1'b0, 16'd0, 0, 0, 32'h0000_00ff, 0);
    cyc(1'b1, (16'd9 << 11) + 2, 32'h0000_000f, 0, 32'h0000_0001, 0);
    cyc(1'b0, (16'd9 << 11) + 2, 0, 0, 0, 0);
    chk("R5", rdata_o, 32'h0000_00f1);

    // R6: sleep bit halts, R7: other bits do not
    cyc(1'b1, 16'd8 << 11, 32'h0000_0020, 0, 0, 32'h0000_4000);
    chk("R6", {31'b0, halt_o}, 32'd1);
    chk("R6", resume_pc_o, 32'h0000_4004);
    cyc(1'b1, 16'd8 << 11, 32'h0000_ffcf, 0, 0, 32'h0000_9000);
    chk("R7", {31'b0, halt_o}, 32'd0);
    chk("R7", resume_pc_o, 32'h0000_4004);

    // R8 / R9 / R10 / R1
    cyc(1'b1, 16'd128, 32'hffff_ffff, 0, 0, 0);
    cyc(1'b0, 16'd128, 0, 32'h7777_7777, 0, 0);
    chk("R8", rdata_o, 32'd3);
    cyc(1'b0, (16'd1 << 11) + 16'd11, 0, 32'h0bad_cafe, 0, 0);
    chk("R1", rdata_o, 32'h0bad_cafe);
    cyc(1'b1, 16'd12, 32'h5a5a_5a5a, 0, 0, 0);
    cyc(1'b0, 16'd12, 0, 32'h0000_1111, 0, 0);
    chk("R10", rdata_o, 32'h0000_1111);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] irq = ($urandom_range(0, 7) == 0) ? 32'($urandom) : 32'h0;
      cyc(1'($urandom_range(0, 1)), pick_addr(int'($urandom)),
          32'($urandom), 32'($urandom), irq, 32'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule